// File: doc/BRIEF.md
# Two-Word Message FIFO Mailbox

This block carries short messages between a host processor and a coprocessor. Messages go both ways. Host-to-coprocessor words queue in an inbound FIFO. Coprocessor-to-host words queue in an outbound FIFO. Both FIFOs sit behind one host data address: a host write to that address pushes a word into the inbound FIFO, and a host read from it pops a word from the outbound FIFO. A message is a pair of 32-bit words, so each FIFO holds two entries by default.

The block has four more pieces. A status register reports, as positive "not empty" and "not full" flags, the level of both FIFOs, together with four interrupt flags. A control register enables each FIFO, and enables each FIFO together with its write path. A one-word mailbox lets the host leave a value for the coprocessor; a fixed pattern written to the mailbox clears it. A watch FIFO lets the coprocessor queue 31-bit trace entries for the host, and each host read of it pops one entry with a valid flag.

The coprocessor side has plain pulse ports: pop the inbound FIFO, push the outbound FIFO, push the watch FIFO, and acknowledge the mailbox. The host side is a simple register port: an address, write and read strobes, and a read result that is registered.

Top module: `mbx_msg_bridge`

## Requirements
- R1: Reset behaviour. After reset:
  - control reads 0;
  - status reads 0x00060000;
  - host_rdata and host_irq are 0;
  - cp_in_valid is 0 and cp_out_ready is 1.
- R2: Host write to address 0. The word is pushed into the inbound FIFO only when control bit 25 is 1; otherwise it is dropped. The coprocessor receives words on cp_in_data in write order. While cp_in_valid is 1 and cp_in_pop is 0, the head word holds steady.
- R3: Inbound depth. The inbound FIFO holds two words. After one accepted word, status bit 17 (inbound not full) is still 1. After two words, status bit 17 is 0, and a third write is dropped.
- R4: Host read from address 0. The read pops the outbound FIFO in push order and returns the word on host_rdata one cycle later. A read of an empty outbound FIFO returns 0 and changes nothing.
- R5: Coprocessor push. A cp_out_push enters the outbound FIFO only when control bit 24 is 1. A push into a full outbound FIFO (two words) is dropped. cp_out_ready is the outbound not-full flag.
- R6: FIFO level flags in status (address 1):
  - bit 16 is outbound not empty;
  - bit 17 is inbound not full;
  - bit 18 is outbound not full;
  - bit 19 is inbound not empty.
- R7: Interrupt flags in status:
  - bit 21 is inbound not empty while control bit 17 or bit 25 is 1;
  - bit 22 is outbound not empty while control bit 16 or bit 24 is 1;
  - each clears when its FIFO drains;
  - host_irq is the OR of status bits 20 to 23, one cycle after the state changes.
- R8: Mailbox write. A host write to address 3 of any value other than 0x0000F0F0 stores the value on cp_mbox_data and sets cp_mbox_pending and status bit 20. A host read from address 3 returns the stored value. cp_mbox_ack clears the pending flag; a host write in the same cycle takes priority over the acknowledge.
- R9: Mailbox clear. A host write of 0x0000F0F0 to address 3 clears the mailbox value to 0 and clears the pending flag.
- R10: Watch FIFO. It is two entries deep and is filled by cp_wp_push with 31-bit cp_wp_data; a push when it is full is dropped. A host read from address 4 returns {1'b1, entry} and pops the entry, or returns 0 when the FIFO is empty. Status bit 23 is watch not empty.
- R11: Control register (address 2). Only bits 16, 17, 24 and 25 are stored. Every other bit reads back as 0.
- R12: Status writes and unmapped addresses. Writes to the status address change nothing. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data, valid the cycle after host_rd |
| host_irq | output | 1 | Host interrupt request |
| cp_in_pop | input | 1 | Coprocessor pops the inbound FIFO |
| cp_in_data | output | 32 | Inbound FIFO head word, 0 when empty |
| cp_in_valid | output | 1 | Inbound FIFO not empty |
| cp_out_push | input | 1 | Coprocessor pushes the outbound FIFO |
| cp_out_data | input | 32 | Word for the outbound FIFO |
| cp_out_ready | output | 1 | Outbound FIFO not full |
| cp_wp_push | input | 1 | Coprocessor pushes the watch FIFO |
| cp_wp_data | input | 31 | Watch entry |
| cp_mbox_ack | input | 1 | Coprocessor acknowledges the mailbox |
| cp_mbox_data | output | 32 | Mailbox value |
| cp_mbox_pending | output | 1 | Mailbox holds an unacknowledged value |

## Verification
The hardest situation to reach from the ports is a FIFO at its exact two-word boundary under a further push. This needs the right control enables, a full FIFO, and a write or coprocessor push landing while nothing drains it. The flags must show not-full after exactly one word and full after two.

A directed sequence fills each FIFO word by word, reading status after every step. Long random runs then interleave pushes, pops, status reads and control changes, so that full-push and empty-pop cases recur under changing enables. Mailbox clear-versus-acknowledge ordering is driven directly.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WP_W   = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_STAT  = 3'd1,
    A_CTRL  = 3'd2,
    A_MBOX  = 3'd3,
    A_WATCH = 3'd4
  } addr_e;

  // status bit positions (software decodes these)
  localparam int unsigned ST_OUT_NE  = 16;
  localparam int unsigned ST_IN_NF   = 17;
  localparam int unsigned ST_OUT_NF  = 18;
  localparam int unsigned ST_IN_NE   = 19;
  localparam int unsigned ST_MB_IRQ  = 20;
  localparam int unsigned ST_IN_IRQ  = 21;
  localparam int unsigned ST_OUT_IRQ = 22;
  localparam int unsigned ST_WP_IRQ  = 23;

  // control bit positions
  localparam int unsigned CT_OUT_EN = 16;
  localparam int unsigned CT_IN_EN  = 17;
  localparam int unsigned CT_OUT_WR = 24;
  localparam int unsigned CT_IN_WR  = 25;

  localparam logic [DATA_W-1:0] CTRL_MASK  = 32'h0303_0000;
  localparam logic [DATA_W-1:0] MBOX_CLEAR = 32'h0000_F0F0;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         not_full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign not_empty = (count != '0);
  assign not_full  = (count != CNT_W'(DEPTH));
  assign do_push   = push && not_full;
  assign do_pop    = pop && not_empty;
  assign head      = not_empty ? mem[rptr] : '0;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack,
  output logic [DATA_W-1:0] value,
  output logic              pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      pending <= 1'b0;
    end else if (wr) begin
      if (wdata == MBOX_CLEAR) begin
        value   <= '0;
        pending <= 1'b0;
      end else begin
        value   <= wdata;
        pending <= 1'b1;
      end
    end else if (ack) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  output logic              in_push,
  output logic              out_pop,
  output logic              wp_pop,
  output logic              mbox_wr,
  output logic              out_wr_en,
  input  logic [DATA_W-1:0] out_head,
  input  logic [WP_W-1:0]   wp_head,
  input  logic              in_ne,
  input  logic              in_nf,
  input  logic              out_ne,
  input  logic              out_nf,
  input  logic              wp_ne,
  input  logic [DATA_W-1:0] mbox_value,
  input  logic              mbox_pending
);
  logic [DATA_W-1:0] ctl, status, rd_mux;
  addr_e             a;

  assign a         = addr_e'(host_addr);
  assign in_push   = host_wr && (a == A_DATA) && ctl[CT_IN_WR];
  assign out_pop   = host_rd && (a == A_DATA);
  assign wp_pop    = host_rd && (a == A_WATCH);
  assign mbox_wr   = host_wr && (a == A_MBOX);
  assign out_wr_en = ctl[CT_OUT_WR];

  always_comb begin
    status             = '0;
    status[ST_OUT_NE]  = out_ne;
    status[ST_IN_NF]   = in_nf;
    status[ST_OUT_NF]  = out_nf;
    status[ST_IN_NE]   = in_ne;
    status[ST_MB_IRQ]  = mbox_pending;
    status[ST_IN_IRQ]  = in_ne && (ctl[CT_IN_EN] || ctl[CT_IN_WR]);
    status[ST_OUT_IRQ] = out_ne && (ctl[CT_OUT_EN] || ctl[CT_OUT_WR]);
    status[ST_WP_IRQ]  = wp_ne;
  end

  always_comb begin
    case (a)
      A_DATA:  rd_mux = out_head;
      A_STAT:  rd_mux = status;
      A_CTRL:  rd_mux = ctl;
      A_MBOX:  rd_mux = mbox_value;
      A_WATCH: rd_mux = wp_ne ? {1'b1, wp_head} : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl        <= '0;
      host_rdata <= '0;
      host_irq   <= 1'b0;
    end else begin
      if (host_wr && (a == A_CTRL)) ctl <= host_wdata & CTRL_MASK;
      if (host_rd) host_rdata <= rd_mux;
      host_irq <= |status[ST_WP_IRQ:ST_MB_IRQ];
    end
  end
endmodule

// File: rtl/mbx_msg_bridge.sv
module mbx_msg_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned IN_DEPTH  = 2,
  parameter int unsigned OUT_DEPTH = 2,
  parameter int unsigned WP_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              cp_in_pop,
  output logic [DATA_W-1:0] cp_in_data,
  output logic              cp_in_valid,
  input  logic              cp_out_push,
  input  logic [DATA_W-1:0] cp_out_data,
  output logic              cp_out_ready,
  input  logic              cp_wp_push,
  input  logic [WP_W-1:0]   cp_wp_data,
  input  logic              cp_mbox_ack,
  output logic [DATA_W-1:0] cp_mbox_data,
  output logic              cp_mbox_pending
);
  logic              in_push, out_pop, wp_pop, mbox_wr, out_wr_en;
  logic              in_nf, out_ne, out_nf, wp_ne, wp_nf;
  logic [DATA_W-1:0] out_head;
  logic [WP_W-1:0]   wp_head;

  mbx_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in (
    .clk(clk), .rst(rst), .push(in_push), .pdata(host_wdata),
    .pop(cp_in_pop), .head(cp_in_data), .not_empty(cp_in_valid),
    .not_full(in_nf));

  mbx_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out (
    .clk(clk), .rst(rst), .push(cp_out_push && out_wr_en),
    .pdata(cp_out_data), .pop(out_pop), .head(out_head),
    .not_empty(out_ne), .not_full(out_nf));

  mbx_fifo #(.W(WP_W), .DEPTH(WP_DEPTH)) u_wp (
    .clk(clk), .rst(rst), .push(cp_wp_push), .pdata(cp_wp_data),
    .pop(wp_pop), .head(wp_head), .not_empty(wp_ne), .not_full(wp_nf));

  mbx_mailbox u_mbox (
    .clk(clk), .rst(rst), .wr(mbox_wr), .wdata(host_wdata),
    .ack(cp_mbox_ack), .value(cp_mbox_data), .pending(cp_mbox_pending));

  mbx_host_regs u_regs (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .in_push(in_push), .out_pop(out_pop),
    .wp_pop(wp_pop), .mbox_wr(mbox_wr), .out_wr_en(out_wr_en),
    .out_head(out_head), .wp_head(wp_head), .in_ne(cp_in_valid),
    .in_nf(in_nf), .out_ne(out_ne), .out_nf(out_nf), .wp_ne(wp_ne),
    .mbox_value(cp_mbox_data), .mbox_pending(cp_mbox_pending));

  assign cp_out_ready = out_nf;

  // the watch not-full flag is not reported anywhere
  logic wp_nf_unused;
  assign wp_nf_unused = wp_nf;
endmodule

// File: rtl/mbx_msg_bridge_chk.sv
module mbx_msg_bridge_chk
  import mbx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_irq,
  input logic              cp_in_pop,
  input logic [DATA_W-1:0] cp_in_data,
  input logic              cp_in_valid,
  input logic              cp_out_push,
  input logic              cp_out_ready,
  input logic              cp_mbox_ack,
  input logic [DATA_W-1:0] cp_mbox_data,
  input logic              cp_mbox_pending
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (host_rdata == '0 && !host_irq && !cp_in_valid && cp_out_ready));

  // R2
  in_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_in_valid && !cp_in_pop) |=> (cp_in_valid && $stable(cp_in_data)));

  // R5
  out_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!cp_out_ready && cp_out_push && !(host_rd && host_addr == A_DATA))
      |=> !cp_out_ready);

  // R8
  mbox_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_mbox_ack && !(host_wr && host_addr == A_MBOX)) |=> !cp_mbox_pending);

  // R9
  mbox_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_MBOX && host_wdata == MBOX_CLEAR)
      |=> (!cp_mbox_pending && cp_mbox_data == '0));
endmodule

bind mbx_msg_bridge mbx_msg_bridge_chk u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .host_irq(host_irq), .cp_in_pop(cp_in_pop), .cp_in_data(cp_in_data),
  .cp_in_valid(cp_in_valid), .cp_out_push(cp_out_push),
  .cp_out_ready(cp_out_ready), .cp_mbox_ack(cp_mbox_ack),
  .cp_mbox_data(cp_mbox_data), .cp_mbox_pending(cp_mbox_pending));

// File: tb/test_mbx_msg_bridge.sv
`timescale 1ns/1ps
module test_mbx_msg_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        cp_in_pop = 1'b0;
  logic [31:0] cp_in_data;
  logic        cp_in_valid;
  logic        cp_out_push = 1'b0;
  logic [31:0] cp_out_data = '0;
  logic        cp_out_ready;
  logic        cp_wp_push = 1'b0;
  logic [30:0] cp_wp_data = '0;
  logic        cp_mbox_ack = 1'b0;
  logic [31:0] cp_mbox_data;
  logic        cp_mbox_pending;

  always #10 clk = ~clk;

  mbx_msg_bridge i_mbx_msg_bridge (.*);

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [31:0] in_q [2];  int in_n = 0;
  logic [31:0] out_q [2]; int out_n = 0;
  logic [30:0] wp_q [2];  int wp_n = 0;
  logic [31:0] m_ctl = '0, m_mbox = '0;
  logic        m_pend = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[16] = out_n > 0;
    s[17] = in_n < 2;
    s[18] = out_n < 2;
    s[19] = in_n > 0;
    s[20] = m_pend;
    s[21] = (in_n > 0) && (m_ctl[17] || m_ctl[25]);
    s[22] = (out_n > 0) && (m_ctl[16] || m_ctl[24]);
    s[23] = wp_n > 0;
    return s;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic h_wr(input logic [2:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic h_rd(input logic [2:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic w_data(input logic [31:0] d);
    h_wr(3'd0, d);
    if (m_ctl[25] && in_n < 2) begin in_q[in_n] = d; in_n++; end
  endtask

  task automatic w_ctl(input logic [31:0] d);
    h_wr(3'd2, d);
    m_ctl = d & 32'h0303_0000;
  endtask

  task automatic r_data(input string tag);
    logic [31:0] d, e;
    e = (out_n > 0) ? out_q[0] : 32'h0;
    h_rd(3'd0, d);
    if (out_n > 0) begin out_q[0] = out_q[1]; out_n--; end
    chk(tag, d, e);
  endtask

  task automatic r_stat(input string tag);
    logic [31:0] d;
    h_rd(3'd1, d);
    chk(tag, d, exp_status());
  endtask

  task automatic cp_pop(input string tag);
    chk(tag, {31'h0, cp_in_valid}, {31'h0, in_n > 0});
    if (in_n > 0) chk(tag, cp_in_data, in_q[0]);
    cp_in_pop = 1'b1;
    tick();
    cp_in_pop = 1'b0;
    if (in_n > 0) begin in_q[0] = in_q[1]; in_n--; end
  endtask

  task automatic cp_push(input logic [31:0] d);
    cp_out_data = d; cp_out_push = 1'b1;
    tick();
    cp_out_push = 1'b0;
    if (m_ctl[24] && out_n < 2) begin out_q[out_n] = d; out_n++; end
  endtask

  task automatic wp_push(input logic [30:0] d);
    cp_wp_data = d; cp_wp_push = 1'b1;
    tick();
    cp_wp_push = 1'b0;
    if (wp_n < 2) begin wp_q[wp_n] = d; wp_n++; end
  endtask

  task automatic r_wp(input string tag);
    logic [31:0] d, e;
    e = (wp_n > 0) ? {1'b1, wp_q[0]} : 32'h0;
    h_rd(3'd4, d);
    if (wp_n > 0) begin wp_q[0] = wp_q[1]; wp_n--; end
    chk(tag, d, e);
  endtask

  task automatic w_mbox(input logic [31:0] d);
    h_wr(3'd3, d);
    if (d == 32'h0000_F0F0) begin m_mbox = '0; m_pend = 1'b0; end
    else begin m_mbox = d; m_pend = 1'b1; end
  endtask

  task automatic chk_irq(input string tag);
    tick();
    chk(tag, {31'h0, host_irq}, {31'h0, |exp_status()[23:20]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 rdata", host_rdata, 32'h0);
    chk("R1 irq", {31'h0, host_irq}, 32'h0);
    chk("R1 in_valid", {31'h0, cp_in_valid}, 32'h0);
    chk("R1 out_ready", {31'h0, cp_out_ready}, 32'h1);
    h_rd(3'd2, d); chk("R1 ctl", d, 32'h0);
    h_rd(3'd1, d); chk("R1 status", d, 32'h0006_0000);

    // R11 control masking
    w_ctl(32'hFFFF_FFFF);
    h_rd(3'd2, d); chk("R11 ctl mask", d, 32'h0303_0000);

    // R2 write path off: word dropped
    w_ctl(32'h0002_0000);
    w_data(32'hDEAD_0001);
    chk("R2 dropped", {31'h0, cp_in_valid}, 32'h0);
    r_stat("R6 status after drop");

    // R3 inbound boundary
    w_ctl(32'h0303_0000);
    w_data(32'hA000_0001);
    h_rd(3'd1, d); chk("R3 one word not full", {31'h0, d[17]}, 32'h1);
    chk("R7 in irq bit", {31'h0, d[21]}, 32'h1);
    chk_irq("R7 irq asserted");
    w_data(32'hA000_0002);
    h_rd(3'd1, d); chk("R3 two words full", {31'h0, d[17]}, 32'h0);
    w_data(32'hA000_0003);
    cp_pop("R2 first word");
    cp_pop("R2 second word");
    cp_pop("R3 third dropped");
    r_stat("R7 in irq clear after drain");

    // R4 empty outbound read
    r_data("R4 empty read zero");
    // R5 outbound full and write path
    cp_push(32'hB000_0001);
    cp_push(32'hB000_0002);
    chk("R5 full ready low", {31'h0, cp_out_ready}, 32'h0);
    cp_push(32'hB000_0003);
    r_stat("R6 out full status");
    r_data("R4 first out");
    r_data("R4 second out");
    r_data("R4 empty again");
    w_ctl(32'h0001_0000);
    cp_push(32'hB000_0004);
    chk("R5 write path off", {31'h0, cp_out_ready}, 32'h1);
    r_stat("R5 status unchanged");

    // R8 mailbox
    w_mbox(32'h1234_5678);
    chk("R8 mbox data", cp_mbox_data, 32'h1234_5678);
    chk("R8 pending", {31'h0, cp_mbox_pending}, 32'h1);
    h_rd(3'd3, d); chk("R8 mbox read", d, 32'h1234_5678);
    cp_mbox_ack = 1'b1; tick(); cp_mbox_ack = 1'b0; m_pend = 1'b0;
    chk("R8 ack clears", {31'h0, cp_mbox_pending}, 32'h0);
    w_mbox(32'h0000_0055);
    // R9 clear pattern
    w_mbox(32'h0000_F0F0);
    chk("R9 cleared value", cp_mbox_data, 32'h0);
    chk("R9 cleared pending", {31'h0, cp_mbox_pending}, 32'h0);

    // R10 watch FIFO
    r_wp("R10 empty watch");
    wp_push(31'h1234_0001);
    wp_push(31'h1234_0002);
    wp_push(31'h1234_0003);
    r_stat("R10 watch status");
    chk_irq("R7 irq from watch");
    r_wp("R10 first entry");
    r_wp("R10 second entry");
    r_wp("R10 empty after");

    // R12 status write ignored, unmapped reads
    w_ctl(32'h0303_0000);
    w_data(32'hC000_0001);
    h_wr(3'd1, 32'hFFFF_FFFF);
    r_stat("R12 status write ignored");
    h_rd(3'd6, d); chk("R12 unmapped", d, 32'h0);
    cp_pop("R12 inbound intact");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        0, 1:    w_data($urandom);
        2:       cp_pop("R2 random pop");
        3, 4:    cp_push($urandom);
        5:       r_data("R4 random read");
        6:       r_stat("R6 random status");
        7:       wp_push(31'($urandom));
        8:       r_wp("R10 random watch");
        9:       begin
                   if ($urandom_range(0, 3) == 0) w_mbox(32'h0000_F0F0);
                   else w_mbox($urandom | 32'h0001_0000);
                 end
        10:      chk_irq("R7 random irq");
        default: begin
                   case ($urandom_range(0, 3))
                     0: w_ctl(32'h0303_0000);
                     1: w_ctl(32'h0003_0000);
                     2: w_ctl(32'h0300_0000);
                     default: w_ctl(32'h0102_0000);
                   endcase
                 end
      endcase
    end
    r_stat("R6 final status");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule